// File: doc/BRIEF.md
# Disk Record Framer with CRC Check

The framer sits behind the bit-recovery stage of an MFM disk read channel. It receives one decoded byte per strobe, each tagged as either a sync-prefix byte (a byte recovered with a deliberately missing clock) or an ordinary byte. From this stream it recognises index marks, ID records and data records. It pulls the cylinder, side, sector and length-code fields out of every ID record. It checks the 16-bit CCITT CRC of every record, and it streams the data-record body out with a running byte index.

Each data record is paired with the ID record that came before it. The pairing holds only if that header passed its CRC, its length code matches the configured sector size, its data mark arrived within a bounded number of bytes, and the line did not go quiet between the two. Five saturating counters (index marks, ID records, data records, CRC passes, CRC failures) can be read on the ports.

Top module: `disk_record_framer`

## Requirements
- R1: A record opens with three consecutive 0xA1 bytes, all tagged sync, followed by a mark byte tagged normal. Mark 0xFE opens an ID record and marks 0xF8 through 0xFB open a data record. A broken prefix run, a sync-tagged mark or any other mark value frames nothing, and the block goes back to hunting for a prefix.
- R2: Three sync-tagged 0xC2 bytes followed by a normal-tagged 0xFC form an index mark. The block then raises `index_pulse` for one cycle and increments `cnt_index`.
- R3: The ID body is four bytes, taken in order as cylinder, side, sector and length code. When the ID CRC passes, `hdr_valid` pulses together with `crc_ok` and the `hdr_*` outputs carry the fields. `hdr_len` is 128, 256, 512 or 1024 for codes 0 to 3, and 0 for any other code.
- R4: The CRC register (polynomial x^16+x^12+x^5+1, MSB first) is preset to 0xFFFF at the first 0xA1. The three prefixes, the mark, the body and the two trailing CRC bytes all feed it. The record passes when the register is zero after the last CRC byte. `crc_ok` or `crc_err` pulses for one cycle, and `crc_is_data` is high with it for data records.
- R5: A data body is exactly 128 << `sect_code` bytes long. Each body byte appears on `data_byte` with `data_valid` high for one cycle, and `data_index` counts up from 0. The two CRC bytes are not presented as data.
- R6: An ID record is remembered for pairing only if its CRC passes and its length code equals `sect_code`. A new ID mark or a failing ID CRC discards it. `pair_hit` rises with a data record's CRC pulse only when a remembered ID was still valid at that record's data mark.
- R7: Pairing also requires that at most MAX_GAP_BYTES (default 68) bytes arrive strictly between the ID mark byte and the data mark byte.
- R8: QUIET_CYCLES (default 3000) consecutive cycles without an input byte discard the remembered ID.
- R9: After a record's last CRC byte, and after an index mark, the next byte is consumed as a gap byte whatever its value or tag. Prefix hunting starts only after that byte.
- R10: The five counters saturate at all ones and never wrap.
- R11: After reset all counters are zero, no pulse is active and no ID is remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | 8 | Decoded byte |
| in_sync | input | 1 | Byte is a sync prefix (missing clock) |
| sect_code | input | 2 | Configured sector size, 128 << code bytes |
| hdr_valid | output | 1 | Pulse: ID record passed its CRC |
| hdr_cyl | output | 8 | Cylinder field |
| hdr_side | output | 8 | Side field |
| hdr_sect | output | 8 | Sector field |
| hdr_code | output | 8 | Length code field |
| hdr_len | output | 11 | Length decoded from the code |
| data_valid | output | 1 | Data byte strobe |
| data_byte | output | 8 | Data record body byte |
| data_index | output | 10 | Position of the byte in the body |
| index_pulse | output | 1 | Pulse: index mark seen |
| crc_ok | output | 1 | Pulse: record CRC passed |
| crc_err | output | 1 | Pulse: record CRC failed |
| crc_is_data | output | 1 | The CRC pulse belongs to a data record |
| pair_hit | output | 1 | The data record is paired with a valid ID |
| cnt_index | output | CNT_W | Index marks seen |
| cnt_id | output | CNT_W | ID records completed |
| cnt_data | output | CNT_W | Data records completed |
| cnt_pass | output | CNT_W | CRC passes |
| cnt_fail | output | CNT_W | CRC failures |

## Verification
Clean ID and data records are sent with each data mark value and with two sector sizes. The same record shapes are then sent with a flipped CRC bit, which separates the pass path from the fail path and shows that the prefixes are covered by the CRC. Framing faults are fed in: a short prefix run, a sync-tagged mark, a stray mark value, and a sync byte placed in the gap slot. Each should frame nothing, which tells prefix counting apart from value matching. Pairing is probed at both sides of its limits: filler runs of 58 and 59 bytes around the gap bound, idle runs below and above the quiet limit, and a length-code mismatch. A run of index marks drives a narrow counter into saturation.

// File: rtl/dfr_pkg.sv
package dfr_pkg;

  typedef enum logic [3:0] {
    S_HUNT, S_A1_2, S_A1_3, S_MARK,
    S_C2_2, S_C2_3, S_IDXM,
    S_IDBODY, S_IDCRC, S_DBODY, S_DCRC, S_GAP
  } fr_state_t;

  localparam logic [7:0] SYNC_REC = 8'hA1;
  localparam logic [7:0] SYNC_IDX = 8'hC2;
  localparam logic [7:0] MARK_IDX = 8'hFC;
  localparam logic [7:0] MARK_ID  = 8'hFE;
  localparam int LEN_W     = 11;
  localparam int IDX_W     = LEN_W - 1;
  localparam int ID_BYTES  = 4;
  localparam int CRC_BYTES = 2;
  localparam int N_CNT     = 5;

  // One byte through the CCITT polynomial, MSB first; unrolls to XOR logic.
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ b[i]) r = {r[14:0], 1'b0} ^ 16'h1021;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [LEN_W-1:0] code_len(input logic [7:0] code);
    case (code)
      8'd0:    return LEN_W'(128);
      8'd1:    return LEN_W'(256);
      8'd2:    return LEN_W'(512);
      8'd3:    return LEN_W'(1024);
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/dfr_crc16.sv
module dfr_crc16 (
  input  logic        clk,
  input  logic        rst,
  input  logic        preset,
  input  logic        update,
  input  logic [7:0]  din,
  output logic [15:0] crc_next
);
  import dfr_pkg::*;

  logic [15:0] crc_q;

  assign crc_next = crc16_step(preset ? 16'hFFFF : crc_q, din);

  always_ff @(posedge clk) begin
    if (rst)         crc_q <= 16'hFFFF;
    else if (update) crc_q <= crc_next;
  end
endmodule

// File: rtl/dfr_sat_cnt.sv
module dfr_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)                  q <= '0;
    else if (inc && q != '1)  q <= q + 1'b1;
  end
endmodule

// File: rtl/dfr_pairing.sv
module dfr_pairing #(
  parameter int QUIET_CYCLES  = 3000,
  parameter int MAX_GAP_BYTES = 68
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic id_mark,
  input  logic id_arm,
  input  logic id_drop,
  output logic pair_now
);
  localparam int GAP_SAT = MAX_GAP_BYTES + 1;
  localparam int GAP_W   = $clog2(GAP_SAT + 1);
  localparam int Q_W     = $clog2(QUIET_CYCLES + 1);

  logic [GAP_W-1:0] gap_cnt;
  logic [Q_W-1:0]   q_cnt;
  logic             armed;
  logic             quiet_exp;

  assign quiet_exp = (q_cnt == Q_W'(QUIET_CYCLES));
  assign pair_now  = armed && !quiet_exp && (gap_cnt <= GAP_W'(MAX_GAP_BYTES));

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt <= GAP_W'(GAP_SAT);
      q_cnt   <= '0;
      armed   <= 1'b0;
    end else begin
      if (in_valid && id_mark)                            gap_cnt <= '0;
      else if (in_valid && gap_cnt != GAP_W'(GAP_SAT))    gap_cnt <= gap_cnt + 1'b1;

      if (in_valid)        q_cnt <= '0;
      else if (!quiet_exp) q_cnt <= q_cnt + 1'b1;

      if (id_arm)                                armed <= 1'b1;
      else if (id_mark || id_drop || quiet_exp)  armed <= 1'b0;
    end
  end
endmodule

// File: rtl/disk_record_framer.sv
module disk_record_framer #(
  parameter int CNT_W         = 16,
  parameter int QUIET_CYCLES  = 3000,
  parameter int MAX_GAP_BYTES = 68
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             in_sync,
  input  logic [1:0]       sect_code,
  output logic             hdr_valid,
  output logic [7:0]       hdr_cyl,
  output logic [7:0]       hdr_side,
  output logic [7:0]       hdr_sect,
  output logic [7:0]       hdr_code,
  output logic [10:0]      hdr_len,
  output logic             data_valid,
  output logic [7:0]       data_byte,
  output logic [9:0]       data_index,
  output logic             index_pulse,
  output logic             crc_ok,
  output logic             crc_err,
  output logic             crc_is_data,
  output logic             pair_hit,
  output logic [CNT_W-1:0] cnt_index,
  output logic [CNT_W-1:0] cnt_id,
  output logic [CNT_W-1:0] cnt_data,
  output logic [CNT_W-1:0] cnt_pass,
  output logic [CNT_W-1:0] cnt_fail
);
  import dfr_pkg::*;

  fr_state_t        state;
  logic [LEN_W-1:0] bcnt;
  logic [LEN_W-1:0] sect_len;
  logic [7:0]       f_cyl, f_side, f_sect, f_code;
  logic             data_paired;
  logic [15:0]      crc_next;

  logic is_rec_sync, is_idx_sync;
  logic crc_preset, crc_upd;
  logic idx_hit, id_mark_hit, dat_mark_hit;
  logic id_done, dat_done, rec_done, crc_zero;
  logic id_arm, id_drop, pair_now;
  logic [N_CNT-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_q [N_CNT];

  assign sect_len     = LEN_W'(128) << sect_code;
  assign is_rec_sync  = in_sync && (in_byte == SYNC_REC);
  assign is_idx_sync  = in_sync && (in_byte == SYNC_IDX);
  assign crc_preset   = in_valid && (state == S_HUNT) && is_rec_sync;
  assign crc_upd      = in_valid && ((state != S_HUNT) || is_rec_sync);
  assign id_mark_hit  = in_valid && (state == S_MARK) && !in_sync && (in_byte == MARK_ID);
  assign dat_mark_hit = in_valid && (state == S_MARK) && !in_sync && (in_byte[7:2] == 6'b111110);
  assign idx_hit      = in_valid && (state == S_IDXM) && !in_sync && (in_byte == MARK_IDX);
  assign id_done      = in_valid && (state == S_IDCRC) && (bcnt == LEN_W'(CRC_BYTES - 1));
  assign dat_done     = in_valid && (state == S_DCRC)  && (bcnt == LEN_W'(CRC_BYTES - 1));
  assign rec_done     = id_done || dat_done;
  assign crc_zero     = (crc_next == 16'h0000);
  assign id_arm       = id_done && crc_zero && (f_code == {6'b0, sect_code});
  assign id_drop      = id_done && !crc_zero;

  dfr_crc16 u_crc (
    .clk      (clk),
    .rst      (rst),
    .preset   (crc_preset),
    .update   (crc_upd),
    .din      (in_byte),
    .crc_next (crc_next)
  );

  dfr_pairing #(
    .QUIET_CYCLES  (QUIET_CYCLES),
    .MAX_GAP_BYTES (MAX_GAP_BYTES)
  ) u_pair (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .id_mark  (id_mark_hit),
    .id_arm   (id_arm),
    .id_drop  (id_drop),
    .pair_now (pair_now)
  );

  assign cnt_inc = {rec_done && !crc_zero, rec_done && crc_zero, dat_done, id_done, idx_hit};

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    dfr_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk (clk),
      .rst (rst),
      .inc (cnt_inc[g]),
      .q   (cnt_q[g])
    );
  end

  assign cnt_index = cnt_q[0];
  assign cnt_id    = cnt_q[1];
  assign cnt_data  = cnt_q[2];
  assign cnt_pass  = cnt_q[3];
  assign cnt_fail  = cnt_q[4];

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_HUNT;
      bcnt        <= '0;
      f_cyl       <= '0;
      f_side      <= '0;
      f_sect      <= '0;
      f_code      <= '0;
      data_paired <= 1'b0;
      hdr_valid   <= 1'b0;
      hdr_cyl     <= '0;
      hdr_side    <= '0;
      hdr_sect    <= '0;
      hdr_code    <= '0;
      hdr_len     <= '0;
      data_valid  <= 1'b0;
      data_byte   <= '0;
      data_index  <= '0;
      index_pulse <= 1'b0;
      crc_ok      <= 1'b0;
      crc_err     <= 1'b0;
      crc_is_data <= 1'b0;
      pair_hit    <= 1'b0;
    end else begin
      hdr_valid   <= 1'b0;
      data_valid  <= 1'b0;
      index_pulse <= 1'b0;
      crc_ok      <= 1'b0;
      crc_err     <= 1'b0;
      crc_is_data <= 1'b0;
      pair_hit    <= 1'b0;
      if (in_valid) begin
        case (state)
          S_HUNT: begin
            if (is_rec_sync)      state <= S_A1_2;
            else if (is_idx_sync) state <= S_C2_2;
          end
          S_A1_2: state <= is_rec_sync ? S_A1_3 : S_HUNT;
          S_A1_3: state <= is_rec_sync ? S_MARK : S_HUNT;
          S_MARK: begin
            bcnt <= '0;
            if (id_mark_hit) begin
              state <= S_IDBODY;
            end else if (dat_mark_hit) begin
              state       <= S_DBODY;
              data_paired <= pair_now;
            end else begin
              state <= S_HUNT;
            end
          end
          S_C2_2: state <= is_idx_sync ? S_C2_3 : S_HUNT;
          S_C2_3: state <= is_idx_sync ? S_IDXM : S_HUNT;
          S_IDXM: begin
            if (idx_hit) begin
              index_pulse <= 1'b1;
              state       <= S_GAP;
            end else begin
              state <= S_HUNT;
            end
          end
          S_IDBODY: begin
            case (bcnt[1:0])
              2'd0:    f_cyl  <= in_byte;
              2'd1:    f_side <= in_byte;
              2'd2:    f_sect <= in_byte;
              default: f_code <= in_byte;
            endcase
            if (bcnt == LEN_W'(ID_BYTES - 1)) begin
              bcnt  <= '0;
              state <= S_IDCRC;
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end
          S_IDCRC: begin
            if (id_done) begin
              state   <= S_GAP;
              crc_ok  <= crc_zero;
              crc_err <= !crc_zero;
              if (crc_zero) begin
                hdr_valid <= 1'b1;
                hdr_cyl   <= f_cyl;
                hdr_side  <= f_side;
                hdr_sect  <= f_sect;
                hdr_code  <= f_code;
                hdr_len   <= code_len(f_code);
              end
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end
          S_DBODY: begin
            data_valid <= 1'b1;
            data_byte  <= in_byte;
            data_index <= bcnt[IDX_W-1:0];
            if (bcnt == sect_len - 1'b1) begin
              bcnt  <= '0;
              state <= S_DCRC;
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end
          S_DCRC: begin
            if (dat_done) begin
              state       <= S_GAP;
              crc_ok      <= crc_zero;
              crc_err     <= !crc_zero;
              crc_is_data <= 1'b1;
              pair_hit    <= data_paired;
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end
          S_GAP:   state <= S_HUNT;
          default: state <= S_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/dfr_checker.sv
module dfr_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             data_valid,
  input logic [9:0]       data_index,
  input logic             hdr_valid,
  input logic             index_pulse,
  input logic             crc_ok,
  input logic             crc_err,
  input logic             crc_is_data,
  input logic             pair_hit,
  input logic [CNT_W-1:0] cnt_index,
  input logic [CNT_W-1:0] cnt_pass
);
  logic [9:0] last_idx;

  always_ff @(posedge clk) begin
    if (rst)             last_idx <= '0;
    else if (data_valid) last_idx <= data_index;
  end

  assert_ok_err_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(crc_ok && crc_err));

  assert_pass_counted_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(cnt_pass) |-> crc_ok);

  assert_hdr_on_pass_R3: assert property (@(posedge clk) disable iff (rst)
    hdr_valid |-> (crc_ok && !crc_is_data));

  assert_pair_qualified_R6: assert property (@(posedge clk) disable iff (rst)
    pair_hit |-> (crc_is_data && (crc_ok || crc_err)));

  assert_index_step_R5: assert property (@(posedge clk) disable iff (rst)
    (data_valid && data_index != 10'd0) |-> (data_index == last_idx + 10'd1));

  assert_index_count_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(cnt_index) |-> index_pulse);

  assert_no_wrap_R10: assert property (@(posedge clk) disable iff (rst)
    (cnt_index == '1) |=> (cnt_index == '1));
endmodule

bind disk_record_framer dfr_checker #(.CNT_W(CNT_W)) u_dfr_chk (
  .clk         (clk),
  .rst         (rst),
  .data_valid  (data_valid),
  .data_index  (data_index),
  .hdr_valid   (hdr_valid),
  .index_pulse (index_pulse),
  .crc_ok      (crc_ok),
  .crc_err     (crc_err),
  .crc_is_data (crc_is_data),
  .pair_hit    (pair_hit),
  .cnt_index   (cnt_index),
  .cnt_pass    (cnt_pass)
);

// File: tb/test_disk_record_framer.sv
module test_disk_record_framer;
  localparam int CW = 3;
  localparam int SAT = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic in_sync = 1'b0;
  logic [1:0] sect_code = 2'd0;
  logic hdr_valid, data_valid, index_pulse, crc_ok, crc_err, crc_is_data, pair_hit;
  logic [7:0] hdr_cyl, hdr_side, hdr_sect, hdr_code, data_byte;
  logic [10:0] hdr_len;
  logic [9:0] data_index;
  logic [CW-1:0] cnt_index, cnt_id, cnt_data, cnt_pass, cnt_fail;

  disk_record_framer #(.CNT_W(CW)) i_disk_record_framer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte), .in_sync(in_sync),
    .sect_code(sect_code), .hdr_valid(hdr_valid), .hdr_cyl(hdr_cyl), .hdr_side(hdr_side),
    .hdr_sect(hdr_sect), .hdr_code(hdr_code), .hdr_len(hdr_len), .data_valid(data_valid),
    .data_byte(data_byte), .data_index(data_index), .index_pulse(index_pulse),
    .crc_ok(crc_ok), .crc_err(crc_err), .crc_is_data(crc_is_data), .pair_hit(pair_hit),
    .cnt_index(cnt_index), .cnt_id(cnt_id), .cnt_data(cnt_data), .cnt_pass(cnt_pass),
    .cnt_fail(cnt_fail)
  );

  always #5 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  int n_hdr, n_ok, n_err, n_pair, n_idx, n_dv;
  int e_idx = 0, e_id = 0, e_data = 0, e_pass = 0, e_fail = 0;
  logic [7:0] l_cyl, l_side, l_sect, l_code;
  logic [10:0] l_len;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int satv(input int v);
    return (v > SAT) ? SAT : v;
  endfunction

  // Polynomial division, one input bit at a time, top bit first.
  function automatic logic [15:0] crc_bit(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int k = 0; k < 8; k++) begin
      logic fb;
      fb = r[15] ^ b[7-k];
      r = r << 1;
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic clear_flags();
    n_hdr = 0; n_ok = 0; n_err = 0; n_pair = 0; n_idx = 0; n_dv = 0;
  endtask

  task automatic send(input logic [7:0] b, input logic s);
    in_valid = 1'b1; in_byte = b; in_sync = s;
    @(negedge clk);
    in_valid = 1'b0; in_sync = 1'b0;
    n_hdr += int'(hdr_valid); n_ok += int'(crc_ok); n_err += int'(crc_err);
    n_pair += int'(pair_hit); n_idx += int'(index_pulse); n_dv += int'(data_valid);
    if (hdr_valid) begin
      l_cyl = hdr_cyl; l_side = hdr_side; l_sect = hdr_sect; l_code = hdr_code; l_len = hdr_len;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) send(8'h4E, 1'b0);
  endtask

  task automatic send_id(input logic [7:0] c, input logic [7:0] sd, input logic [7:0] sc,
                         input logic [7:0] lc, input bit bad, input bit gap);
    logic [15:0] crc;
    logic [7:0] body [4];
    body[0] = c; body[1] = sd; body[2] = sc; body[3] = lc;
    crc = 16'hFFFF;
    for (int i = 0; i < 3; i++) begin crc = crc_bit(crc, 8'hA1); send(8'hA1, 1'b1); end
    crc = crc_bit(crc, 8'hFE); send(8'hFE, 1'b0);
    for (int i = 0; i < 4; i++) begin crc = crc_bit(crc, body[i]); send(body[i], 1'b0); end
    send(crc[15:8], 1'b0);
    send(crc[7:0] ^ {7'b0, bad}, 1'b0);
    if (gap) send(8'h4E, 1'b0);
    e_id++;
    if (bad) e_fail++; else e_pass++;
  endtask

  task automatic send_data(input logic [7:0] mark, input int len, input int seed,
                           input bit bad, input string req);
    logic [15:0] crc;
    int nbad;
    nbad = 0;
    crc = 16'hFFFF;
    for (int i = 0; i < 3; i++) begin crc = crc_bit(crc, 8'hA1); send(8'hA1, 1'b1); end
    crc = crc_bit(crc, mark); send(mark, 1'b0);
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = 8'((i * 7 + seed) & 255);
      crc = crc_bit(crc, b);
      send(b, 1'b0);
      if (!(data_valid && data_byte == b && data_index == 10'(i))) nbad++;
    end
    send(crc[15:8], 1'b0);
    if (data_valid) nbad++;
    send(crc[7:0] ^ {7'b0, bad}, 1'b0);
    if (data_valid) nbad++;
    send(8'h4E, 1'b0);
    chk(req, nbad, 0);
    e_data++;
    if (bad) e_fail++; else e_pass++;
  endtask

  task automatic send_index();
    for (int i = 0; i < 3; i++) send(8'hC2, 1'b1);
    send(8'hFC, 1'b0);
    send(8'h4E, 1'b0);
    e_idx++;
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    clear_flags();
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 counters", int'(cnt_index) + int'(cnt_id) + int'(cnt_data) + int'(cnt_pass) + int'(cnt_fail), 0);
    chk("R11 pulses", int'(hdr_valid) + int'(crc_ok) + int'(crc_err) + int'(data_valid) + int'(pair_hit), 0);
    // R11: no ID remembered after reset
    clear_flags(); send_data(8'hFB, 128, 3, 0, "R5 body after reset");
    chk("R11 no pairing from reset", n_pair, 0);

    // R1 R3 R4 clean ID then data, R6 pairing
    clear_flags(); send_id(8'd10, 8'd1, 8'd5, 8'd0, 0, 1);
    chk("R3 hdr_valid", n_hdr, 1); chk("R4 id crc_ok", n_ok, 1); chk("R4 id no err", n_err, 0);
    chk("R3 cyl", l_cyl, 10); chk("R3 side", l_side, 1); chk("R3 sect", l_sect, 5);
    chk("R3 code", l_code, 0); chk("R3 len 128", l_len, 128);
    clear_flags(); send_data(8'hFB, 128, 1, 0, "R5 body 128");
    chk("R4 data crc_ok", n_ok, 1); chk("R6 paired", n_pair, 1); chk("R5 strobe count", n_dv, 128);

    // R4 bad data CRC, F8 mark
    clear_flags(); send_id(8'd2, 8'd0, 8'd9, 8'd0, 0, 1);
    clear_flags(); send_data(8'hF8, 128, 5, 1, "R5 body F8");
    chk("R4 data crc_err", n_err, 1); chk("R4 data no ok", n_ok, 0); chk("R6 pair with bad data", n_pair, 1);

    // R6 length mismatch, R3 length decoding
    clear_flags(); send_id(8'd3, 8'd1, 8'd1, 8'd1, 0, 1);
    chk("R3 len 256", l_len, 256);
    clear_flags(); send_data(8'hFA, 128, 7, 0, "R5 body FA");
    chk("R6 length mismatch unpaired", n_pair, 0);
    clear_flags(); send_id(8'd4, 8'd0, 8'd2, 8'd7, 0, 1);
    chk("R3 len code7 zero", l_len, 0); chk("R3 code7 hdr", n_hdr, 1);

    // R4 R6 bad ID CRC
    clear_flags(); send_id(8'd5, 8'd0, 8'd3, 8'd0, 1, 1);
    chk("R4 id crc_err", n_err, 1); chk("R3 no hdr on bad crc", n_hdr, 0);
    clear_flags(); send_data(8'hF9, 128, 9, 0, "R5 body F9");
    chk("R6 bad id unpaired", n_pair, 0);

    // R7 gap bound: 10 fixed bytes + filler between the marks
    clear_flags(); send_id(8'd6, 8'd0, 8'd4, 8'd0, 0, 1); fill(58);
    clear_flags(); send_data(8'hFB, 128, 11, 0, "R5 body gap68");
    chk("R7 gap 68 paired", n_pair, 1);
    clear_flags(); send_id(8'd6, 8'd0, 8'd4, 8'd0, 0, 1); fill(59);
    clear_flags(); send_data(8'hFB, 128, 13, 0, "R5 body gap69");
    chk("R7 gap 69 unpaired", n_pair, 0);

    // R8 quiet line
    clear_flags(); send_id(8'd7, 8'd0, 8'd6, 8'd0, 0, 1); idle(2900);
    clear_flags(); send_data(8'hFB, 128, 15, 0, "R5 body short idle");
    chk("R8 short idle paired", n_pair, 1);
    clear_flags(); send_id(8'd7, 8'd0, 8'd6, 8'd0, 0, 1); idle(3100);
    clear_flags(); send_data(8'hFB, 128, 17, 0, "R5 body long idle");
    chk("R8 long idle unpaired", n_pair, 0);

    // R2 index mark
    clear_flags(); send_index();
    chk("R2 index pulse", n_idx, 1); chk("R2 index count", cnt_index, 1);

    // R1 framing faults: short prefix, sync-tagged mark, bad mark value
    clear_flags();
    send(8'hA1, 1); send(8'hA1, 1); send(8'hA1, 0); send(8'hFE, 0); fill(6);
    send(8'hA1, 1); send(8'hA1, 1); send(8'hA1, 1); send(8'hFE, 1); fill(6);
    send(8'hA1, 1); send(8'hA1, 1); send(8'hA1, 1); send(8'h55, 0); fill(6);
    send(8'hC2, 1); send(8'hC2, 1); send(8'hC2, 1); send(8'hFC, 1); fill(2);
    chk("R1 faults frame nothing", n_hdr + n_ok + n_err + n_dv + n_idx, 0);
    chk("R1 id count unchanged", cnt_id, satv(e_id));

    // R9 gap byte swallowed after index mark, then after an ID record
    clear_flags();
    for (int i = 0; i < 3; i++) send(8'hC2, 1'b1);
    send(8'hFC, 1'b0);
    e_idx++;
    send_id(8'd8, 8'd0, 8'd1, 8'd0, 0, 1);
    e_id--; e_pass--;
    chk("R9 gap after index eats prefix", n_hdr + n_ok + n_err, 0);
    clear_flags(); send_id(8'd9, 8'd1, 8'd2, 8'd0, 0, 0);
    send_id(8'd9, 8'd1, 8'd3, 8'd0, 0, 1);
    e_id--; e_pass--;
    chk("R9 gap after record eats prefix", n_hdr, 1);

    // R5 sector size 256
    sect_code = 2'd1;
    clear_flags(); send_id(8'd20, 8'd1, 8'd8, 8'd1, 0, 1);
    clear_flags(); send_data(8'hFB, 256, 21, 0, "R5 body 256");
    chk("R5 256 strobes", n_dv, 256); chk("R6 paired 256", n_pair, 1); chk("R4 256 crc_ok", n_ok, 1);
    sect_code = 2'd0;

    // R10 saturation
    for (int i = 0; i < 8; i++) send_index();
    chk("R10 cnt_index", cnt_index, satv(e_idx));
    chk("R10 cnt_id", cnt_id, satv(e_id));
    chk("R10 cnt_data", cnt_data, satv(e_data));
    chk("R10 cnt_pass", cnt_pass, satv(e_pass));
    chk("R10 cnt_fail", cnt_fail, satv(e_fail));

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule